// File: doc/BRIEF.md
# SMBus Register-Access Slave with Alert Response

This block is the serial front end of a monitoring device. It watches the two-wire bus (clock and data), recognises START and STOP conditions, shifts in a seven-bit address and a direction bit, and acknowledges when the address is its own. It drives the data line only by pulling it low, so the pad may be wired as open-drain. Behind it sits a simple register file, reached through an address, write data, a one-cycle write strobe and combinational read data.

Every write transaction first loads an internal byte pointer. A second byte in the same write goes to the register the pointer selects. A read transaction returns the selected register and leaves the pointer alone, so a register can be polled repeatedly without rewriting the pointer. The upper five address bits are fixed. The two low bits are decoded from a three-level board strap and latched at the first sign of bus activity after reset. The block also holds an interrupt flag. While that flag is set, the block answers a read of the bus-wide alert response address with its own address. If it wins the bit-wise arbitration against other responders, the flag is cleared.

Top module: `smbus_reg_slave`

## Requirements
- R1: The slave address is binary 01011 followed by A1 and A0. The strap code on `strap_i` is 00 for tied low, 01 for open and 10 for tied high (11 counts as open). These decode to A1A0 = 00, 10 and 01 respectively. A matching address byte is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and SDA is pulled low only while SCL is low.
- R2: The strap is captured once, at the first low level seen on either bus line after reset. Later strap changes do not alter the address until the next reset.
- R3: The first byte after the address in a write transaction is loaded into the pointer, shown on `reg_addr_o`. It produces no write strobe, and no strobe occurs during a read.
- R4: The second byte of a write transaction is acknowledged and produces exactly one cycle of `reg_we_o`, with `reg_wdata_o` equal to that byte and `reg_addr_o` equal to the pointer.
- R5: A third or later byte of a write transaction is not acknowledged and writes nothing.
- R6: A read transaction sends `reg_rdata_i` for the current pointer, most significant bit first, and does not change the pointer. Each further byte the master acknowledges repeats the same register. A master NACK ends the transfer with SDA released.
- R7: While `irq_o` is high, a read of address 0001100 is acknowledged and returns the slave's own address in bits 7..1 with bit 0 at 0. When that byte completes, `irq_o` clears. `irq_set_i` sets `irq_o`.
- R8: While `irq_o` is low, address 0001100 is not acknowledged and `irq_o` stays low.
- R9: If the slave releases SDA to send a 1 and samples SDA low, it has lost arbitration. It releases SDA for the rest of the transaction and `irq_o` stays set.
- R10: A STOP (SDA rising while SCL is high) at any point returns the slave to idle with SDA released. In idle and after reset the slave never drives SDA.
- R11: Both bus lines pass through a two-stage synchronizer and a filter. A pulse shorter than `FILT_LEN` system clocks on SCL or SDA has no effect on the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset (power-up reset) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 2 | Decoded three-level strap: 00 low, 01 open, 10 high |
| irq_set_i | input | 1 | One-cycle pulse that raises the interrupt flag |
| irq_o | output | 1 | Interrupt flag, cleared by a won alert response |
| reg_addr_o | output | 8 | Register pointer presented to the register file |
| reg_wdata_o | output | 8 | Data byte for a register write |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register file read data for `reg_addr_o` |

## Verification
The hardest situation to reach from the ports is a lost arbitration during the alert response. It needs a competing responder that pulls SDA low in exactly the bit where this slave sends a 1. The bench creates this by having its master model drive a chosen bit pattern during the read. The bits after the lost position must then read back as released, and the interrupt must remain set. Sub-threshold glitches are the second hard case. They are injected as single-cycle pulses on SCL, and on SDA inside an SCL high phase where they would otherwise look like a START, in the middle of an address byte that must still be acknowledged.

// File: rtl/smb_pkg.sv
// Package: shared state type, fixed address constants and the strap decode
// used by the bus slave. Assumes 8-bit bytes and a 7-bit bus address.
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // no transaction in progress
        ST_RX,      // receiving a byte (address or data)
        ST_RX_ACK,  // holding our acknowledge during the ninth clock
        ST_TX,      // sending a byte to the master
        ST_TX_ACK,  // waiting for the master's ACK/NACK
        ST_SKIP     // not addressed / aborted: wait for START or STOP
    } smb_state_e;

    localparam logic [4:0] DEV_ADDR_HI  = 5'b01011;
    localparam logic [6:0] ALERT_ADDR   = 7'b0001100;

    // Strap level to low address bits: low->00, high->01, open->10.
    function automatic logic [1:0] strap_decode(input logic [1:0] lvl);
        case (lvl)
            2'b00:   return 2'b00;
            2'b10:   return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
// Module: smb_line_filter
// Brings one asynchronous bus line into the clock domain through a
// SYNC_STAGES flop chain, then lets the output follow only after the
// synchronized value has differed from it for FILT_LEN consecutive cycles.
// Assumes SYNC_STAGES >= 2 and FILT_LEN >= 2; the idle bus level is high.
module smb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_q;
    logic                   dout_q;

    // Synchronizer chain, reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    // Filter: count cycles of disagreement, switch once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b1;
            run_q  <= '0;
        end else if (sync_q[SYNC_STAGES-1] == dout_q) begin
            run_q  <= '0;
        end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
            dout_q <= sync_q[SYNC_STAGES-1];
            run_q  <= '0;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign dout = dout_q;

    AST_FILT_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_q != $past(dout_q)) |=> (dout_q == $past(dout_q)))
        else $error("filtered line toggled on consecutive cycles"); // R11

endmodule

// File: rtl/smb_strap_latch.sv
// Module: smb_strap_latch
// Captures the decoded strap once, on the first cycle that shows bus
// activity after reset, and holds it until the next reset.
// Assumes strap_i is a static board level already resolved into a code.
module smb_strap_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_active,
    input  logic [1:0] strap_i,
    output logic [1:0] addr_lo_o
);

    import smb_pkg::*;

    logic       taken_q;
    logic [1:0] addr_lo_q;

    // One-shot capture of the strap at first activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q   <= 1'b0;
            addr_lo_q <= 2'b10;
        end else if (!taken_q && bus_active) begin
            taken_q   <= 1'b1;
            addr_lo_q <= strap_decode(strap_i);
        end
    end

    assign addr_lo_o = addr_lo_q;

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(taken_q) |-> $stable(addr_lo_q))
        else $error("latched address bits changed"); // R2

endmodule

// File: rtl/smbus_reg_slave.sv
// Module: smbus_reg_slave
// Bus slave with a byte pointer in front of a register file, plus the
// alert response. Decodes START/STOP from filtered lines, receives the
// address byte and the write bytes, sends read bytes, acknowledges, and
// arbitrates during the alert response.
// Assumes: the master never stretches the clock, the SCL low and high
// phases last many system clocks beyond the filter latency, and
// reg_rdata_i follows reg_addr_o combinationally.
module smbus_reg_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [4:0] ADDR_HI     = smb_pkg::DEV_ADDR_HI,
    parameter logic [6:0] ARA_ADDR    = smb_pkg::ALERT_ADDR
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] strap_i,
    input  logic       irq_set_i,
    output logic       irq_o,
    output logic [7:0] reg_addr_o,
    output logic [7:0] reg_wdata_o,
    output logic       reg_we_o,
    input  logic [7:0] reg_rdata_i
);

    import smb_pkg::*;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int LINES  = 2;   // index 0: SCL, index 1: SDA

    // ---------------- line conditioning ----------------
    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] filt_lines;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        smb_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_lines[g]),
            .dout  (filt_lines[g])
        );
    end

    logic scl_f, sda_f, scl_q, sda_q;
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    // Previous filtered levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  =  scl_f & ~scl_q;
    assign scl_fall  = ~scl_f &  scl_q;
    assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
    assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

    // ---------------- address strap ----------------
    logic [1:0] addr_lo;

    smb_strap_latch u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_active (~scl_f | ~sda_f),
        .strap_i    (strap_i),
        .addr_lo_o  (addr_lo)
    );

    logic [6:0] own_addr;
    assign own_addr = {ADDR_HI, addr_lo};

    // ---------------- protocol state ----------------
    smb_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       byte_idx_q;  // 0 address, 1 pointer, 2 data, 3 surplus
    logic [7:0]       shift_q;
    logic [7:0]       tx_sr_q;
    logic [7:0]       ptr_q;
    logic [7:0]       wdata_q;
    logic             we_q;
    logic             ack_q;
    logic             rd_q;
    logic             ara_q;
    logic             lost_q;
    logic             m_ack_q;
    logic             sda_oe_q;
    logic             irq_q;

    logic [7:0] rx_byte;
    logic [7:0] tx_load;
    logic       ara_done;

    assign rx_byte  = {shift_q[6:0], sda_f};
    assign tx_load  = ara_q ? {own_addr, 1'b0} : reg_rdata_i;
    assign ara_done = (state_q == ST_TX) && scl_fall && !lost_q && ara_q
                      && (cnt_q == CNT_W'(BYTE_W));

    // Main transaction sequencer: conditions first, then SCL edge work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            byte_idx_q <= 2'd0;
            shift_q    <= '0;
            tx_sr_q    <= '0;
            ptr_q      <= '0;
            wdata_q    <= '0;
            we_q       <= 1'b0;
            ack_q      <= 1'b0;
            rd_q       <= 1'b0;
            ara_q      <= 1'b0;
            lost_q     <= 1'b0;
            m_ack_q    <= 1'b0;
            sda_oe_q   <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (stop_det) begin
                state_q  <= ST_IDLE;
                sda_oe_q <= 1'b0;
            end else if (start_det) begin
                state_q    <= ST_RX;
                cnt_q      <= '0;
                byte_idx_q <= 2'd0;
                sda_oe_q   <= 1'b0;
                lost_q     <= 1'b0;
                ara_q      <= 1'b0;
                rd_q       <= 1'b0;
            end else begin
                case (state_q)
                    ST_RX: begin
                        if (scl_rise && cnt_q < CNT_W'(BYTE_W)) begin
                            shift_q <= rx_byte;
                            cnt_q   <= cnt_q + 1'b1;
                            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                                if (byte_idx_q != 2'd3) byte_idx_q <= byte_idx_q + 1'b1;
                                case (byte_idx_q)
                                    2'd0: begin
                                        if (rx_byte[7:1] == own_addr) begin
                                            ack_q <= 1'b1;
                                            rd_q  <= rx_byte[0];
                                            ara_q <= 1'b0;
                                        end else if (rx_byte[7:1] == ARA_ADDR && rx_byte[0] && irq_q) begin
                                            ack_q <= 1'b1;
                                            rd_q  <= 1'b1;
                                            ara_q <= 1'b1;
                                        end else begin
                                            ack_q <= 1'b0;
                                        end
                                    end
                                    2'd1: begin
                                        ptr_q <= rx_byte;
                                        ack_q <= 1'b1;
                                    end
                                    2'd2: begin
                                        wdata_q <= rx_byte;
                                        we_q    <= 1'b1;
                                        ack_q   <= 1'b1;
                                    end
                                    default: ack_q <= 1'b0;
                                endcase
                            end
                        end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                            if (ack_q) begin
                                sda_oe_q <= 1'b1;
                                state_q  <= ST_RX_ACK;
                            end else begin
                                state_q  <= ST_SKIP;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rd_q) begin
                                tx_sr_q  <= tx_load;
                                sda_oe_q <= ~tx_load[7];
                                state_q  <= ST_TX;
                            end else begin
                                sda_oe_q <= 1'b0;
                                state_q  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            if (tx_sr_q[7] && !sda_f) lost_q <= 1'b1;
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (lost_q) begin
                                sda_oe_q <= 1'b0;
                                state_q  <= ST_SKIP;
                            end else if (cnt_q == CNT_W'(BYTE_W)) begin
                                sda_oe_q <= 1'b0;
                                state_q  <= ST_TX_ACK;
                            end else begin
                                tx_sr_q  <= {tx_sr_q[6:0], 1'b0};
                                sda_oe_q <= ~tx_sr_q[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            m_ack_q <= ~sda_f;
                        end else if (scl_fall) begin
                            cnt_q <= '0;
                            if (m_ack_q) begin
                                tx_sr_q  <= tx_load;
                                sda_oe_q <= ~tx_load[7];
                                state_q  <= ST_TX;
                            end else begin
                                state_q  <= ST_SKIP;
                            end
                        end
                    end
                    default: ;  // ST_IDLE and ST_SKIP wait for a condition
                endcase
            end
        end
    end

    // Interrupt flag: set by request, cleared by a won alert response.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (irq_set_i) irq_q <= 1'b1;
        else if (ara_done)  irq_q <= 1'b0;
    end

    assign sda_oe_o    = sda_oe_q;
    assign irq_o       = irq_q;
    assign reg_addr_o  = ptr_q;
    assign reg_wdata_o = wdata_q;
    assign reg_we_o    = we_q;

    // ---------------- assertions ----------------
    AST_DRIVE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_q) |-> !scl_f)
        else $error("SDA pulled low while SCL high"); // R1

    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> !reg_we_o)
        else $error("write strobe during a read"); // R3

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o)
        else $error("write strobe longer than one cycle"); // R4

    AST_PTR_HOLD_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX) |=> $stable(ptr_q))
        else $error("pointer moved during a read"); // R6

    AST_IRQ_CLR_ARA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> $past(ara_q))
        else $error("interrupt cleared outside alert response"); // R7

    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !sda_oe_q)
        else $error("SDA driven after losing or NACK"); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe_q)
        else $error("SDA driven in idle"); // R10

endmodule

// File: tb/smbus_reg_slave_bench.sv
// Bench: master model on an open-drain bus, a register file model, random
// write/read traffic plus directed corner cases.
module smbus_reg_slave_bench;

    localparam int Q = 20;          // quarter SCL period in system clocks
    localparam logic [6:0] ARA = 7'b0001100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;          // 50 MHz

    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       irq_set = 1'b0;

    logic       sda_oe, irq, we;
    logic [7:0] raddr, wdata, rdata;
    logic       sda_line;
    assign sda_line = sda_m & ~sda_oe;

    logic [7:0] mem [256];
    int         we_count;
    assign rdata = mem[raddr];

    // Register file model.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
            we_count <= 0;
        end else if (we) begin
            mem[raddr] <= wdata;
            we_count   <= we_count + 1;
        end
    end

    smbus_reg_slave u_smbus_reg_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_i     (strap),
        .irq_set_i   (irq_set),
        .irq_o       (irq),
        .reg_addr_o  (raddr),
        .reg_wdata_o (wdata),
        .reg_we_o    (we),
        .reg_rdata_i (rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_mem [256];

    function automatic logic [6:0] own_of(input logic [1:0] s);
        case (s)
            2'b00:   return 7'b0101100;
            2'b10:   return 7'b0101101;
            default: return 7'b0101110;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst_n = 1'b0;
        strap = s;
        scl_m = 1'b1;
        sda_m = 1'b1;
        tick(5);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 37 + 5);
        tick(5);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    // One clock: glitch 1 = one-cycle SCL low pulse, 2 = one-cycle SDA flip.
    task automatic clk_bit(input logic b, input int glitch, output logic s);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        if (glitch == 1) begin scl_m = 1'b0; tick(1); scl_m = 1'b1; end
        if (glitch == 2) begin sda_m = ~b;   tick(1); sda_m = b;    end
        tick(Q / 2);
        s = sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int gpos, input int gkind,
                             output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], (i == gpos) ? gkind : 0, s);
        clk_bit(1'b1, 0, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic [7:0] mdrive, input logic mack,
                             output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(mdrive[i], 0, s);
            d[i] = s;
        end
        clk_bit(~mack, 0, s);
    endtask

    logic [6:0] own;
    logic       a0, a1, a2;
    logic [7:0] d0, d1, p, v;
    int         wc;

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset(2'b01);
        own = own_of(2'b01);
        // R10 reset state
        chk("R10 sda_oe after reset", sda_oe, 0);
        chk("R7 irq after reset", irq, 0);
        chk("R4 no strobe after reset", we, 0);

        // R1/R3: pointer-only write to own address
        wc = we_count;
        bus_start(); send_byte({own, 1'b0}, -1, 0, a0); send_byte(8'h33, -1, 0, a1); bus_stop();
        chk("R1 ack own address", a0, 1);
        chk("R3 pointer loaded", raddr, 8'h33);
        chk("R3 no write strobe", we_count, wc);

        // R1 mismatch
        bus_start(); send_byte({7'b0101100, 1'b0}, -1, 0, a0); bus_stop();
        chk("R1 no ack foreign address", a0, 0);

        // R2: strap change after capture has no effect
        strap = 2'b00;
        bus_start(); send_byte({own, 1'b0}, -1, 0, a0); send_byte(8'h40, -1, 0, a1); bus_stop();
        chk("R2 old address still acked", a0, 1);
        chk("R2 pointer through old address", raddr, 8'h40);
        bus_start(); send_byte({7'b0101100, 1'b0}, -1, 0, a0); bus_stop();
        chk("R2 new strap address ignored", a0, 0);

        // R4/R6: random writes and read-backs
        for (int k = 0; k < 8; k++) begin
            p = 8'($urandom);
            v = 8'($urandom);
            wc = we_count;
            bus_start(); send_byte({own, 1'b0}, -1, 0, a0); send_byte(p, -1, 0, a1);
            send_byte(v, -1, 0, a2); bus_stop();
            exp_mem[p] = v;
            chk("R4 data byte acked", {a0, a1, a2}, 3'b111);
            chk("R4 one strobe", we_count, wc + 1);
            // read-byte with repeated start, on a random other register too
            if (k[0]) p = 8'($urandom);
            bus_start(); send_byte({own, 1'b0}, -1, 0, a0); send_byte(p, -1, 0, a1);
            bus_start(); send_byte({own, 1'b1}, -1, 0, a2); read_byte(8'hFF, 1'b0, d0); bus_stop();
            chk("R6 read-byte data", d0, exp_mem[p]);
            chk("R6 read acked", {a0, a1, a2}, 3'b111);
        end

        // R5: third byte not acked, not written
        wc = we_count;
        bus_start(); send_byte({own, 1'b0}, -1, 0, a0); send_byte(8'h10, -1, 0, a0);
        send_byte(8'hAA, -1, 0, a1); send_byte(8'hBB, -1, 0, a2); bus_stop();
        exp_mem[8'h10] = 8'hAA;
        chk("R5 surplus byte NACK", a2, 0);
        chk("R5 single strobe", we_count, wc + 1);

        // R6: receive-byte, two bytes, same register, pointer unchanged
        bus_start(); send_byte({own, 1'b1}, -1, 0, a0);
        read_byte(8'hFF, 1'b1, d0); read_byte(8'hFF, 1'b0, d1); bus_stop();
        chk("R6 first byte", d0, 8'hAA);
        chk("R6 repeated byte", d1, 8'hAA);
        chk("R6 pointer unchanged", raddr, 8'h10);
        chk("R6 released after NACK", sda_oe, 0);

        // R8: alert address ignored without interrupt
        bus_start(); send_byte({ARA, 1'b1}, -1, 0, a0); bus_stop();
        chk("R8 no ack without irq", a0, 0);
        chk("R8 irq stays low", irq, 0);

        // R7: alert response returns own address and clears
        irq_set = 1'b1; tick(1); irq_set = 1'b0; tick(2);
        chk("R7 irq set", irq, 1);
        bus_start(); send_byte({ARA, 1'b1}, -1, 0, a0); read_byte(8'hFF, 1'b0, d0); bus_stop();
        chk("R7 ack alert address", a0, 1);
        chk("R7 returned address", d0, {own, 1'b0});
        chk("R7 irq cleared", irq, 0);

        // R9: lose arbitration at bit 6 (slave sends 1, line forced 0)
        irq_set = 1'b1; tick(1); irq_set = 1'b0; tick(2);
        bus_start(); send_byte({ARA, 1'b1}, -1, 0, a0); read_byte(8'b1011_1111, 1'b0, d0); bus_stop();
        chk("R9 bits after loss released", d0, 8'h3F);
        chk("R9 irq kept after loss", irq, 1);

        // R10: STOP in the middle of an address byte
        bus_start(); clk_bit(1'b0, 0, a1); clk_bit(1'b1, 0, a1);
        clk_bit(1'b0, 0, a1); clk_bit(1'b1, 0, a1); bus_stop();
        chk("R10 released after abort", sda_oe, 0);
        bus_start(); send_byte({own, 1'b0}, -1, 0, a0); bus_stop();
        chk("R10 next transaction acked", a0, 1);

        // R11: glitches inside an address byte
        bus_start(); send_byte({own, 1'b0}, 3, 1, a0); bus_stop();
        chk("R11 SCL glitch ignored", a0, 1);
        bus_start(); send_byte({own, 1'b0}, 3, 2, a0); bus_stop();
        chk("R11 SDA glitch ignored", a0, 1);

        // R1/R2: other strap levels after a fresh reset
        do_reset(2'b10);
        bus_start(); send_byte({own_of(2'b10), 1'b0}, -1, 0, a0); bus_stop();
        chk("R1 strap high address", a0, 1);
        do_reset(2'b00);
        bus_start(); send_byte({own_of(2'b00), 1'b0}, -1, 0, a0); bus_stop();
        chk("R2 strap low after reset", a0, 1);
        bus_start(); send_byte({own_of(2'b01), 1'b0}, -1, 0, a0); bus_stop();
        chk("R1 open address rejected", a0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule